// File: doc/BRIEF.md
# Burst Address Generator with Selectable Count Order

This block produces the word address presented to a synchronous burst SRAM array. A new external address is captured whenever one of two address strobes is accepted; from then on the block walks through a four-word group on its own, moving on by one beat on each clock edge where the advance input is high. Only the two lowest address bits take part in the walk. The upper bits keep the value from the last load until the next load arrives.

The order of the walk is chosen by a mode input. With the mode low, the low bits follow an interleaved pattern: the starting value XORed with the beat index. Low is also the value a pull-down tie-off gives, so interleaved order is the default. With the mode high, the low bits count upward from the starting value and wrap modulo four. Bursting is optional. A strobe may be applied on every cycle, and each one loads a fresh address. One strobe is qualified by a chip-select input. The other is always honoured.

Top module: `burst_addr_gen`

## Requirements
- R1: One clock edge after a synchronous reset (`rst`=1), `burst_addr` is 0 and the beat index is 0.
- R2: At a rising edge with `strobe_ctl`=1, or with `strobe_proc`=1 and `chip_sel`=1, `burst_addr` equals that edge's `ext_addr` right after the edge.
- R3: `strobe_proc` has no effect while `chip_sel`=0. `strobe_ctl` loads regardless of `chip_sel`.
- R4: If a load and `advance`=1 fall on the same edge, the load wins and the beat index restarts at 0.
- R5: Bits `[ADDR_W-1:2]` of `burst_addr` change only on a load.
- R6: The beat index k increases by one modulo 4 at each edge with `advance`=1 and no load. With `advance`=0 and no load, `burst_addr` holds.
- R7: With `order_linear`=1, bits `[1:0]` of `burst_addr` equal (start + k) mod 4, where start is bits `[1:0]` of the loaded address.
- R8: With `order_linear`=0 (interleaved, the default tie-off), bits `[1:0]` equal start XOR k.
- R9: After four advances from a load, `burst_addr` is back at the loaded address.
- R10: Loads on consecutive cycles each take effect in the cycle after their edge.
- R11: `order_linear` acts combinationally on the stored start and beat index. Changing it mid-burst remaps the current beat without clocking.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| ext_addr | input | ADDR_W | External word address to load |
| strobe_proc | input | 1 | Address strobe, accepted only with `chip_sel` high |
| strobe_ctl | input | 1 | Address strobe, always accepted |
| chip_sel | input | 1 | Qualifier for `strobe_proc` |
| advance | input | 1 | Step the burst by one beat |
| order_linear | input | 1 | 1 = linear order, 0 = interleaved order |
| burst_addr | output | ADDR_W | Current internal word address |

## Verification
A load and an advance can fall on the same edge. The bench raises a strobe in the middle of a running burst while `advance` stays high. It then requires the next address to be exactly the newly presented one, with no beat added. It also requires the following advance to step from beat 0 of the new start. A gated `strobe_proc` together with an advance is judged separately: the address must step within the old group and must not pick up the presented address.

// File: rtl/burst_addr_pkg.sv
package burst_addr_pkg;

    localparam int BEAT_W = 2;

    typedef enum logic {
        ORD_INTERLEAVE = 1'b0,
        ORD_LINEAR     = 1'b1
    } burst_order_e;

    typedef logic [BEAT_W-1:0] beat_t;

    typedef struct packed {
        beat_t start;
        beat_t beat;
    } burst_state_t;

    function automatic beat_t map_low(burst_order_e ord, beat_t s, beat_t k);
        if (ord == ORD_LINEAR)
            return beat_t'(s + k);
        else
            return s ^ k;
    endfunction

endpackage

// File: rtl/burst_load_qual.sv
module burst_load_qual (
    input  logic strobe_proc,
    input  logic strobe_ctl,
    input  logic chip_sel,
    input  logic advance,
    output logic load,
    output logic step
);
    always_comb begin
        load = strobe_ctl | (strobe_proc & chip_sel);
        step = advance & ~load;
    end
endmodule

// File: rtl/burst_beat_ctr.sv
module burst_beat_ctr
    import burst_addr_pkg::*;
(
    input  logic         clk,
    input  logic         rst,
    input  logic         load,
    input  logic         step,
    input  beat_t        start_in,
    output burst_state_t state
);
    always_ff @(posedge clk) begin
        if (rst) begin
            state <= '0;
        end else if (load) begin
            state.start <= start_in;
            state.beat  <= '0;
        end else if (step) begin
            state.beat  <= beat_t'(state.beat + 1'b1);
        end
    end
endmodule

// File: rtl/burst_upper_reg.sv
module burst_upper_reg #(
    parameter int UP_W = 18
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            load,
    input  logic [UP_W-1:0] d,
    output logic [UP_W-1:0] q
);
    always_ff @(posedge clk) begin
        if (rst)
            q <= '0;
        else if (load)
            q <= d;
    end
endmodule

// File: rtl/burst_low_map.sv
module burst_low_map
    import burst_addr_pkg::*;
(
    input  logic         order_linear,
    input  burst_state_t state,
    output beat_t        low
);
    burst_order_e ord;
    always_comb begin
        ord = burst_order_e'(order_linear);
        low = map_low(ord, state.start, state.beat);
    end
endmodule

// File: rtl/burst_addr_gen.sv
module burst_addr_gen
    import burst_addr_pkg::*;
#(
    parameter int ADDR_W = 20
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] ext_addr,
    input  logic              strobe_proc,
    input  logic              strobe_ctl,
    input  logic              chip_sel,
    input  logic              advance,
    input  logic              order_linear,
    output logic [ADDR_W-1:0] burst_addr
);
    localparam int UP_W = ADDR_W - BEAT_W;

    logic         load;
    logic         step;
    burst_state_t state;
    beat_t        low;
    logic [UP_W-1:0] upper;

    burst_load_qual u_qual (
        .strobe_proc (strobe_proc),
        .strobe_ctl  (strobe_ctl),
        .chip_sel    (chip_sel),
        .advance     (advance),
        .load        (load),
        .step        (step)
    );

    burst_beat_ctr u_ctr (
        .clk      (clk),
        .rst      (rst),
        .load     (load),
        .step     (step),
        .start_in (ext_addr[BEAT_W-1:0]),
        .state    (state)
    );

    burst_upper_reg #(.UP_W(UP_W)) u_upper (
        .clk  (clk),
        .rst  (rst),
        .load (load),
        .d    (ext_addr[ADDR_W-1:BEAT_W]),
        .q    (upper)
    );

    burst_low_map u_map (
        .order_linear (order_linear),
        .state        (state),
        .low          (low)
    );

    assign burst_addr = {upper, low};
endmodule

// File: rtl/burst_addr_gen_chk.sv
module burst_addr_gen_chk #(
    parameter int ADDR_W = 20
) (
    input logic              clk,
    input logic              rst,
    input logic [ADDR_W-1:0] ext_addr,
    input logic              strobe_proc,
    input logic              strobe_ctl,
    input logic              chip_sel,
    input logic              advance,
    input logic              order_linear,
    input logic [ADDR_W-1:0] burst_addr
);
    logic accepted;
    assign accepted = strobe_ctl | (strobe_proc & chip_sel);

    // R2, R4, R10: an accepted strobe lands exactly, advance or not
    assert_load_R2: assert property (@(posedge clk) disable iff (rst)
        accepted |=> burst_addr == $past(ext_addr));

    // R3: gated strobe never pulls in the presented upper bits
    assert_gated_R3: assert property (@(posedge clk) disable iff (rst)
        (strobe_proc && !chip_sel && !strobe_ctl)
        |=> burst_addr[ADDR_W-1:2] == $past(burst_addr[ADDR_W-1:2]));

    // R5: upper bits move only on a load
    assert_upper_hold_R5: assert property (@(posedge clk) disable iff (rst)
        !accepted |=> $stable(burst_addr[ADDR_W-1:2]));

    // R6: no load and no advance keeps the address, unless the order flips
    assert_hold_R6: assert property (@(posedge clk) disable iff (rst)
        (!accepted && !advance)
        |=> ($stable(burst_addr) || !$stable(order_linear)));

    // R7: linear order steps the low bits by one
    assert_linear_step_R7: assert property (@(posedge clk) disable iff (rst)
        (!accepted && advance && order_linear)
        |=> (!order_linear
             || burst_addr[1:0] == 2'($past(burst_addr[1:0]) + 2'd1)));
endmodule

bind burst_addr_gen burst_addr_gen_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk          (clk),
    .rst          (rst),
    .ext_addr     (ext_addr),
    .strobe_proc  (strobe_proc),
    .strobe_ctl   (strobe_ctl),
    .chip_sel     (chip_sel),
    .advance      (advance),
    .order_linear (order_linear),
    .burst_addr   (burst_addr)
);

// File: tb/burst_addr_gen_test.sv
module burst_addr_gen_test;
    localparam int AW = 20;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [AW-1:0] ext_addr = '0;
    logic          strobe_proc = 1'b0;
    logic          strobe_ctl = 1'b0;
    logic          chip_sel = 1'b0;
    logic          advance = 1'b0;
    logic          order_linear = 1'b0;
    logic [AW-1:0] burst_addr;

    int n_run = 0;
    int n_fail = 0;
    bit finished = 1'b0;

    always #2.5 clk = ~clk;

    burst_addr_gen #(.ADDR_W(AW)) uut (
        .clk(clk), .rst(rst), .ext_addr(ext_addr),
        .strobe_proc(strobe_proc), .strobe_ctl(strobe_ctl),
        .chip_sel(chip_sel), .advance(advance),
        .order_linear(order_linear), .burst_addr(burst_addr)
    );

    task automatic check(input string tag, input logic [AW-1:0] exp);
        n_run++;
        if (burst_addr !== exp) begin
            n_fail++;
            $display("FAIL %s: burst_addr=%h expected %h", tag, burst_addr, exp);
        end
    endtask

    // Drive at the falling edge, then sample 1 ns after the next rising edge.
    task automatic cyc(input logic sp, input logic sc, input logic cs,
                       input logic adv, input logic [AW-1:0] a);
        @(negedge clk);
        strobe_proc = sp; strobe_ctl = sc; chip_sel = cs;
        advance = adv; ext_addr = a;
        @(posedge clk);
        #1;
    endtask

    task automatic t_reset;
        @(negedge clk); rst = 1'b1;
        cyc(0, 1, 1, 1, 20'hFFFFF);
        cyc(0, 0, 0, 0, '0);
        check("R1 reset", '0);
        @(negedge clk); rst = 1'b0;
    endtask

    task automatic t_ctl_load;
        cyc(0, 1, 0, 0, 20'h12345);
        check("R2/R3 ctl strobe loads with chip_sel=0", 20'h12345);
    endtask

    task automatic t_proc_gate;
        cyc(0, 1, 1, 0, 20'h00010);
        cyc(1, 0, 0, 0, 20'hABCDE);
        check("R3 proc strobe ignored, no advance", 20'h00010);
        cyc(1, 0, 0, 1, 20'hABCDE);
        order_linear = 1'b0;
        check("R3 proc strobe ignored, advance steps", 20'h00011);
        cyc(1, 0, 1, 0, 20'hABCDE);
        check("R2 proc strobe with chip_sel", 20'hABCDE);
    endtask

    task automatic t_linear;
        logic [1:0] exp_low [4] = '{2'd3, 2'd0, 2'd1, 2'd2};
        @(negedge clk); order_linear = 1'b1;
        cyc(0, 1, 0, 0, 20'h0F0F2);
        check("R2 linear load", 20'h0F0F2);
        for (int k = 0; k < 4; k++) begin
            cyc(0, 0, 0, 1, 20'h55555);
            check($sformatf("R7/R5/R9 linear beat %0d", k + 1),
                  {18'(20'h0F0F2 >> 2), exp_low[k]});
        end
    endtask

    task automatic t_interleave;
        logic [1:0] exp_low [4] = '{2'd0, 2'd3, 2'd2, 2'd1};
        @(negedge clk); order_linear = 1'b0;
        cyc(0, 1, 0, 0, 20'hA5A51);
        check("R2 interleaved load", 20'hA5A51);
        for (int k = 0; k < 4; k++) begin
            cyc(0, 0, 0, 1, '0);
            check($sformatf("R8/R9 interleaved beat %0d", k + 1),
                  {18'(20'hA5A51 >> 2), exp_low[k]});
        end
    endtask

    task automatic t_hold;
        cyc(0, 0, 0, 1, '0);
        for (int k = 0; k < 3; k++) begin
            cyc(0, 0, 0, 0, 20'hFFFFF);
            check("R6 no advance holds", 20'hA5A50);
        end
    endtask

    task automatic t_priority;
        @(negedge clk); order_linear = 1'b1;
        cyc(0, 1, 0, 0, 20'h00400);
        cyc(0, 0, 0, 1, '0);
        check("R7 pre-priority step", 20'h00401);
        cyc(0, 1, 0, 1, 20'h77772);
        check("R4 load beats advance", 20'h77772);
        cyc(0, 0, 0, 1, '0);
        check("R4 beat restarts at 0", 20'h77773);
    endtask

    task automatic t_back_to_back;
        logic [AW-1:0] seq [4] = '{20'h11111, 20'h22222, 20'h33333, 20'h44440};
        for (int k = 0; k < 4; k++) begin
            cyc(k[0], ~k[0], 1, 1, seq[k]);
            check($sformatf("R10 back-to-back load %0d", k), seq[k]);
        end
    endtask

    task automatic t_mode_switch;
        @(negedge clk); order_linear = 1'b0;
        cyc(0, 1, 0, 0, 20'h00003);
        cyc(0, 0, 0, 1, '0);
        check("R8 interleaved start 3 beat 1", 20'h00002);
        @(negedge clk); advance = 1'b0; order_linear = 1'b1;
        #1;
        check("R11 order switch remaps beat 1", 20'h00000);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_run++; n_fail++;
            $display("FAIL watchdog: run did not finish");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        t_reset();
        t_ctl_load();
        t_proc_gate();
        t_linear();
        t_interleave();
        t_hold();
        t_priority();
        t_back_to_back();
        t_mode_switch();
        finished = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule